// File: doc/BRIEF.md
# Last-Writer Table with Sub-Register Aliasing

This block keeps, for each architectural register, the tag of the newest in-flight instruction that will write it. A consumer looks up a source register and gets back the producers it must wait for. Registers alias each other. Every full register has a low half and a high half. A write to a full register also covers both halves. A write to a half covers its full register only when the writer updates that whole full register.

Three ports share one table:

- **Write port.** It records a writer tag and a full-update flag.
- **Retire port.** It removes a writer, but only from entries that still name it. A newer writer is therefore never erased.
- **Lookup port.** It is combinational. It returns up to three distinct producer tags in fixed priority order, with a valid mask.

When a write and a retire arrive in the same cycle, the retire is applied first and the write second.

Register numbering, with `F = NUM_FULL`:

| Register | ID |
|---|---|
| Invalid | 0 |
| Full register f | f, for 1..F |
| Low half of full f | F+f |
| High half of full f | 2F+f |

With the default F = 8 there are IDs 0..24.

Top module: `lwt_table`

## Requirements
- R1: After reset every entry is empty, so a lookup of any ID 0..3F returns `lk_valid` = 3'b000.
- R2: ID 0 and IDs above 3F are never recorded. A write naming them changes no entry, and a lookup of ID 0 always returns `lk_valid` = 3'b000.
- R3: A write to full register f stores `wr_tag` in entry f and in both half entries F+f and 2F+f, whatever the value of `wr_full`. A write to a half stores the tag in that half's entry.
- R4: A write to a half (F+f or 2F+f) stores its tag in full entry f only when `wr_full` = 1. A write with `wr_full` = 0 leaves entry f unchanged.
- R5: A retire of register r clears entry r, and for a full register also both half entries. Each entry is cleared only where it still holds `rt_tag`. Entries holding another tag, or already empty, are unchanged.
- R6: A retire of a half clears its full register's entry only when parameter CLR_SUPER = 1, and only if that entry holds `rt_tag`. With CLR_SUPER = 0 the full entry is untouched.
- R7: A lookup fills the output slots in this order, skipping any tag already present in an earlier slot:
  1. the register's own writer, if valid;
  2. then, for a full register, the low-half writer;
  3. then the high-half writer.

  Valid slots are packed from slot 0, so `lk_valid` is one of 000, 001, 011 or 111. A half has no sub-registers, so its lookup yields at most one tag.
- R8: A write and a retire in the same cycle are applied retire first, then write. The new writer's tag is therefore always present after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; empties the table |
| wr_en | input | 1 | Record a new writer this cycle |
| wr_reg | input | ID_W (5) | Destination register ID of the writer |
| wr_tag | input | TAG_W (6) | Tag of the writer |
| wr_full | input | 1 | Writer updates the whole enclosing full register |
| rt_en | input | 1 | Retire a writer this cycle |
| rt_reg | input | ID_W (5) | Destination register ID of the retiring writer |
| rt_tag | input | TAG_W (6) | Tag of the retiring writer |
| lk_reg | input | ID_W (5) | Source register ID to look up |
| lk_valid | output | 3 | Valid mask of the three producer slots, packed from bit 0 |
| lk_tag0 | output | TAG_W (6) | Producer tag in slot 0 |
| lk_tag1 | output | TAG_W (6) | Producer tag in slot 1 |
| lk_tag2 | output | TAG_W (6) | Producer tag in slot 2 |

## Verification
The assertions check every cycle that:
- the lookup mask is packed and its valid slots never repeat a tag;
- ID 0 and the halves never report more than their own writer;
- a write is visible at the next lookup of its register;
- a retire without a competing write leaves no trace of its tag under that register.

Only the bench scenarios can show the ordering of producers across own and half writers. They also show:
- that a partial write leaves the full register alone;
- that a retire spares entries a newer writer has taken;
- the effect of the CLR_SUPER parameter, by comparing a second instance built with it set.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

    localparam int DEF_NUM_FULL = 8;
    localparam int DEF_TAG_W    = 6;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_FULL = 2'd1,
        CLS_LOW  = 2'd2,
        CLS_HIGH = 2'd3
    } alias_cls_e;

endpackage

// File: rtl/lwt_alias_map.sv
module lwt_alias_map
    import lwt_pkg::*;
#(
    parameter int NUM_FULL = DEF_NUM_FULL,
    parameter int NUM_REGS = 3 * NUM_FULL + 1,
    parameter int ID_W     = $clog2(NUM_REGS)
) (
    input  logic [ID_W-1:0]     reg_id,
    output alias_cls_e          cls,
    output logic [NUM_REGS-1:0] self_mask,
    output logic [NUM_REGS-1:0] sub_mask,
    output logic [NUM_REGS-1:0] sup_mask
);

    localparam logic [ID_W-1:0] LOW_BASE  = ID_W'(NUM_FULL);
    localparam logic [ID_W-1:0] HIGH_BASE = ID_W'(2 * NUM_FULL);
    localparam logic [ID_W-1:0] TOP_ID    = ID_W'(3 * NUM_FULL);

    always_comb begin
        if (reg_id == '0 || reg_id > TOP_ID)
            cls = CLS_NONE;
        else if (reg_id <= LOW_BASE)
            cls = CLS_FULL;
        else if (reg_id <= HIGH_BASE)
            cls = CLS_LOW;
        else
            cls = CLS_HIGH;
    end

    assign self_mask[0] = 1'b0;
    assign sub_mask[0]  = 1'b0;
    assign sup_mask[0]  = 1'b0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_ent
        assign self_mask[i] = (reg_id == ID_W'(i));
        if (i <= NUM_FULL) begin : g_full
            assign sub_mask[i] = 1'b0;
            assign sup_mask[i] = ((cls == CLS_LOW)  && (reg_id == ID_W'(i + NUM_FULL))) ||
                                 ((cls == CLS_HIGH) && (reg_id == ID_W'(i + 2 * NUM_FULL)));
        end else if (i <= 2 * NUM_FULL) begin : g_low
            assign sub_mask[i] = (cls == CLS_FULL) && (reg_id == ID_W'(i - NUM_FULL));
            assign sup_mask[i] = 1'b0;
        end else begin : g_high
            assign sub_mask[i] = (cls == CLS_FULL) && (reg_id == ID_W'(i - 2 * NUM_FULL));
            assign sup_mask[i] = 1'b0;
        end
    end

endmodule

// File: rtl/lwt_merge.sv
module lwt_merge #(
    parameter int TAG_W = 6
) (
    input  logic             own_v,
    input  logic [TAG_W-1:0] own_t,
    input  logic             lo_v,
    input  logic [TAG_W-1:0] lo_t,
    input  logic             hi_v,
    input  logic [TAG_W-1:0] hi_t,
    output logic [2:0]       valid,
    output logic [TAG_W-1:0] tag0,
    output logic [TAG_W-1:0] tag1,
    output logic [TAG_W-1:0] tag2
);

    logic             lo_new;
    logic             hi_new;
    logic [1:0]       cnt;
    logic [TAG_W-1:0] slot [3];

    always_comb begin
        lo_new = lo_v && !(own_v && (lo_t == own_t));
        hi_new = hi_v && !(own_v && (hi_t == own_t)) && !(lo_new && (hi_t == lo_t));

        cnt = 2'd0;
        for (int k = 0; k < 3; k++) slot[k] = '0;
        if (own_v) begin
            slot[cnt] = own_t;
            cnt       = cnt + 2'd1;
        end
        if (lo_new) begin
            slot[cnt] = lo_t;
            cnt       = cnt + 2'd1;
        end
        if (hi_new) begin
            slot[cnt] = hi_t;
            cnt       = cnt + 2'd1;
        end

        case (cnt)
            2'd0:    valid = 3'b000;
            2'd1:    valid = 3'b001;
            2'd2:    valid = 3'b011;
            default: valid = 3'b111;
        endcase
        tag0 = slot[0];
        tag1 = slot[1];
        tag2 = slot[2];
    end

endmodule

// File: rtl/lwt_table.sv
module lwt_table
    import lwt_pkg::*;
#(
    parameter int NUM_FULL  = DEF_NUM_FULL,
    parameter int TAG_W     = DEF_TAG_W,
    parameter bit CLR_SUPER = 1'b0,
    localparam int NUM_REGS = 3 * NUM_FULL + 1,
    localparam int ID_W     = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_reg,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_full,
    input  logic             rt_en,
    input  logic [ID_W-1:0]  rt_reg,
    input  logic [TAG_W-1:0] rt_tag,
    input  logic [ID_W-1:0]  lk_reg,
    output logic [2:0]       lk_valid,
    output logic [TAG_W-1:0] lk_tag0,
    output logic [TAG_W-1:0] lk_tag1,
    output logic [TAG_W-1:0] lk_tag2
);

    typedef struct packed {
        logic [NUM_REGS-1:0]            vld;
        logic [NUM_REGS-1:0][TAG_W-1:0] tag;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    alias_cls_e          wr_cls, rt_cls, lk_cls;
    logic [NUM_REGS-1:0] wr_self, wr_sub, wr_sup;
    logic [NUM_REGS-1:0] rt_self, rt_sub, rt_sup;
    logic [NUM_REGS-1:0] lk_self, lk_sub, lk_sup;

    lwt_alias_map #(.NUM_FULL(NUM_FULL), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_wr_map (
        .reg_id(wr_reg), .cls(wr_cls),
        .self_mask(wr_self), .sub_mask(wr_sub), .sup_mask(wr_sup)
    );

    lwt_alias_map #(.NUM_FULL(NUM_FULL), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_rt_map (
        .reg_id(rt_reg), .cls(rt_cls),
        .self_mask(rt_self), .sub_mask(rt_sub), .sup_mask(rt_sup)
    );

    lwt_alias_map #(.NUM_FULL(NUM_FULL), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_lk_map (
        .reg_id(lk_reg), .cls(lk_cls),
        .self_mask(lk_self), .sub_mask(lk_sub), .sup_mask(lk_sup)
    );

    // Next state: retire is applied first, the write then overrides it (R8).
    always_comb begin
        tbl_d = tbl_q;
        for (int i = 1; i < NUM_REGS; i++) begin
            if (rt_en && (rt_self[i] || rt_sub[i] || (CLR_SUPER && rt_sup[i])) &&
                tbl_q.vld[i] && (tbl_q.tag[i] == rt_tag))
                tbl_d.vld[i] = 1'b0;
            if (wr_en && (wr_self[i] || wr_sub[i] || (wr_full && wr_sup[i]))) begin
                tbl_d.vld[i] = 1'b1;
                tbl_d.tag[i] = wr_tag;
            end
        end
        tbl_d.vld[0] = 1'b0;
        tbl_d.tag[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tbl_q <= '0;
        else
            tbl_q <= tbl_d;
    end

    // Lookup read-out: own entry, then low and high halves of a full register.
    logic             own_v, lo_v, hi_v;
    logic [TAG_W-1:0] own_t, lo_t, hi_t;

    always_comb begin
        own_v = 1'b0;
        lo_v  = 1'b0;
        hi_v  = 1'b0;
        own_t = '0;
        lo_t  = '0;
        hi_t  = '0;
        for (int i = 1; i < NUM_REGS; i++) begin
            if (lk_self[i]) begin
                own_v = tbl_q.vld[i];
                own_t = tbl_q.tag[i];
            end
            if (lk_sub[i] && i <= 2 * NUM_FULL) begin
                lo_v = tbl_q.vld[i];
                lo_t = tbl_q.tag[i];
            end
            if (lk_sub[i] && i > 2 * NUM_FULL) begin
                hi_v = tbl_q.vld[i];
                hi_t = tbl_q.tag[i];
            end
        end
    end

    lwt_merge #(.TAG_W(TAG_W)) u_merge (
        .own_v(own_v), .own_t(own_t),
        .lo_v(lo_v),   .lo_t(lo_t),
        .hi_v(hi_v),   .hi_t(hi_t),
        .valid(lk_valid),
        .tag0(lk_tag0), .tag1(lk_tag1), .tag2(lk_tag2)
    );

endmodule

// File: rtl/lwt_table_chk.sv
module lwt_table_chk #(
    parameter int NUM_FULL  = 8,
    parameter int TAG_W     = 6,
    localparam int NUM_REGS = 3 * NUM_FULL + 1,
    localparam int ID_W     = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [ID_W-1:0]  wr_reg,
    input logic [TAG_W-1:0] wr_tag,
    input logic             wr_full,
    input logic             rt_en,
    input logic [ID_W-1:0]  rt_reg,
    input logic [TAG_W-1:0] rt_tag,
    input logic [ID_W-1:0]  lk_reg,
    input logic [2:0]       lk_valid,
    input logic [TAG_W-1:0] lk_tag0,
    input logic [TAG_W-1:0] lk_tag1,
    input logic [TAG_W-1:0] lk_tag2
);

    localparam logic [ID_W-1:0] TOP_ID = ID_W'(3 * NUM_FULL);
    localparam logic [ID_W-1:0] LOW_LO = ID_W'(NUM_FULL + 1);

    // R2: register 0 never reports a producer.
    assert_reg0_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_reg == '0) |-> (lk_valid == 3'b000));

    // R7: valid slots are packed from slot 0.
    assert_packed_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid == 3'b000) || (lk_valid == 3'b001) ||
        (lk_valid == 3'b011) || (lk_valid == 3'b111));

    // R7: valid slots never repeat a tag.
    assert_distinct_tags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid[1] || (lk_tag1 != lk_tag0)) &&
        (!lk_valid[2] || ((lk_tag2 != lk_tag0) && (lk_tag2 != lk_tag1))));

    // R7: a half register has no sub-registers, so at most one producer.
    assert_half_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((lk_reg >= LOW_LO) && (lk_reg <= TOP_ID)) |-> !lk_valid[1]);

    // R3 / R8: a write is visible at the next lookup of its register.
    assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_reg != '0) && (wr_reg <= TOP_ID)) |=>
        ((lk_reg != $past(wr_reg)) || (lk_valid[0] && (lk_tag0 == $past(wr_tag)))));

    // R5: after a retire with no write, its tag is gone from that register.
    assert_retire_gone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_en && !wr_en && (rt_reg != '0) && (rt_reg <= TOP_ID)) |=>
        ((lk_reg != $past(rt_reg)) ||
         (!(lk_valid[0] && lk_tag0 == $past(rt_tag)) &&
          !(lk_valid[1] && lk_tag1 == $past(rt_tag)) &&
          !(lk_valid[2] && lk_tag2 == $past(rt_tag)))));

endmodule

bind lwt_table lwt_table_chk #(.NUM_FULL(NUM_FULL), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/sim_lwt_table.sv
module sim_lwt_table;

    localparam int F = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_full = 1'b0, rt_en = 1'b0;
    logic [4:0] wr_reg = '0, rt_reg = '0, lk_reg = '0;
    logic [5:0] wr_tag = '0, rt_tag = '0;
    logic [2:0] v0, v1;
    logic [5:0] a0, a1, a2, b0, b1, b2;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lwt_table #(.NUM_FULL(F), .TAG_W(6), .CLR_SUPER(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_tag(wr_tag),
        .wr_full(wr_full), .rt_en(rt_en), .rt_reg(rt_reg), .rt_tag(rt_tag),
        .lk_reg(lk_reg), .lk_valid(v0), .lk_tag0(a0), .lk_tag1(a1), .lk_tag2(a2)
    );

    lwt_table #(.NUM_FULL(F), .TAG_W(6), .CLR_SUPER(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_tag(wr_tag),
        .wr_full(wr_full), .rt_en(rt_en), .rt_reg(rt_reg), .rt_tag(rt_tag),
        .lk_reg(lk_reg), .lk_valid(v1), .lk_tag0(b0), .lk_tag1(b1), .lk_tag2(b2)
    );

    typedef struct packed {
        logic [1:0] op;     // 0 none, 1 write, 2 retire
        logic [4:0] rg;
        logic [5:0] tg;
        logic       full;
        logic [4:0] lk;
        logic [2:0] ev;
        logic [5:0] e0;
        logic [5:0] e1;
        logic [5:0] e2;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd1,  5'd3,  6'd5, 1'b0,  5'd3, 3'b001,  6'd5,  6'd0, 6'd0}, // R3 write full, halves share tag
        '{2'd1, 5'd11,  6'd7, 1'b0,  5'd3, 3'b011,  6'd5,  6'd7, 6'd0}, // R4 partial low half
        '{2'd1, 5'd19,  6'd9, 1'b0,  5'd3, 3'b111,  6'd5,  6'd7, 6'd9}, // R7 three producers
        '{2'd0,  5'd0,  6'd0, 1'b0, 5'd11, 3'b001,  6'd7,  6'd0, 6'd0}, // R7 half lookup
        '{2'd1, 5'd19, 6'd12, 1'b1,  5'd3, 3'b011, 6'd12,  6'd7, 6'd0}, // R4 full-update half, R7 dedup
        '{2'd2,  5'd3,  6'd5, 1'b0,  5'd3, 3'b011, 6'd12,  6'd7, 6'd0}, // R5 stale tag ignored
        '{2'd2, 5'd19, 6'd12, 1'b0,  5'd3, 3'b011, 6'd12,  6'd7, 6'd0}, // R6 super kept
        '{2'd0,  5'd0,  6'd0, 1'b0, 5'd19, 3'b000,  6'd0,  6'd0, 6'd0}, // R5 half cleared
        '{2'd2,  5'd3, 6'd12, 1'b0,  5'd3, 3'b001,  6'd7,  6'd0, 6'd0}, // R5 own cleared, sub moves up
        '{2'd2, 5'd11,  6'd7, 1'b0,  5'd3, 3'b000,  6'd0,  6'd0, 6'd0}, // R5 empty again
        '{2'd1,  5'd0, 6'd33, 1'b1,  5'd0, 3'b000,  6'd0,  6'd0, 6'd0}, // R2 id 0 not written
        '{2'd1, 5'd30, 6'd34, 1'b1, 5'd14, 3'b000,  6'd0,  6'd0, 6'd0}, // R2 out of range not written
        '{2'd1,  5'd5, 6'd40, 1'b1, 5'd21, 3'b001, 6'd40,  6'd0, 6'd0}, // R3 high half of 5
        '{2'd2,  5'd5, 6'd40, 1'b0, 5'd13, 3'b000,  6'd0,  6'd0, 6'd0}, // R5 low half cleared
        '{2'd1, 5'd20,  6'd2, 1'b1,  5'd4, 3'b001,  6'd2,  6'd0, 6'd0}, // R4 full-update high half
        '{2'd1, 5'd12,  6'd3, 1'b0,  5'd4, 3'b011,  6'd2,  6'd3, 6'd0}, // R7 own then low
        '{2'd2, 5'd12,  6'd3, 1'b0,  5'd4, 3'b001,  6'd2,  6'd0, 6'd0}  // R5 low retired
    };

    task automatic check(input string req, input logic [2:0] av, input logic [5:0] t0,
                         input logic [5:0] t1, input logic [5:0] t2, input logic [2:0] ev,
                         input logic [5:0] e0, input logic [5:0] e1, input logic [5:0] e2);
        logic ok;
        ok = (av == ev) && (!ev[0] || t0 == e0) && (!ev[1] || t1 == e1) && (!ev[2] || t2 == e2);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: lk_reg=%0d actual v=%b t=%0d,%0d,%0d expected v=%b t=%0d,%0d,%0d",
                     req, lk_reg, av, t0, t1, t2, ev, e0, e1, e2);
        end
    endtask

    task automatic step(input logic do_wr, input logic [4:0] wrg, input logic [5:0] wtg,
                        input logic wf, input logic do_rt, input logic [4:0] rrg,
                        input logic [5:0] rtg, input logic [4:0] lk);
        @(negedge clk);
        wr_en = do_wr; wr_reg = wrg; wr_tag = wtg; wr_full = wf;
        rt_en = do_rt; rt_reg = rrg; rt_tag = rtg;
        @(negedge clk);
        wr_en = 1'b0; rt_en = 1'b0;
        lk_reg = lk;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every ID empty.
        for (int r = 0; r <= 3 * F; r++) begin
            lk_reg = 5'(r);
            #1;
            check("R1", v0, a0, a1, a2, 3'b000, 6'd0, 6'd0, 6'd0);
        end

        for (int k = 0; k < NV; k++) begin
            step(VEC[k].op == 2'd1, VEC[k].rg, VEC[k].tg, VEC[k].full,
                 VEC[k].op == 2'd2, VEC[k].rg, VEC[k].tg, VEC[k].lk);
            check($sformatf("vector %0d (R2-R7 table)", k), v0, a0, a1, a2,
                  VEC[k].ev, VEC[k].e0, VEC[k].e1, VEC[k].e2);
        end

        // R8: same-cycle retire of old writer and write of a new one.
        step(1'b1, 5'd6, 6'd10, 1'b0, 1'b0, 5'd0, 6'd0, 5'd6);
        step(1'b1, 5'd6, 6'd11, 1'b0, 1'b1, 5'd6, 6'd10, 5'd6);
        check("R8 same reg", v0, a0, a1, a2, 3'b001, 6'd11, 6'd0, 6'd0);
        step(1'b1, 5'd14, 6'd15, 1'b0, 1'b1, 5'd6, 6'd11, 5'd6);
        check("R8 half write", v0, a0, a1, a2, 3'b001, 6'd15, 6'd0, 6'd0);
        lk_reg = 5'd22;
        #1;
        check("R5 high cleared", v0, a0, a1, a2, 3'b000, 6'd0, 6'd0, 6'd0);

        // R1: reset in mid-run empties the table.
        @(negedge clk);
        rst_n = 1'b0;
        lk_reg = 5'd14;
        #1;
        check("R1 mid-run reset", v0, a0, a1, a2, 3'b000, 6'd0, 6'd0, 6'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: super clear on retire depends on CLR_SUPER.
        step(1'b1, 5'd19, 6'd12, 1'b1, 1'b0, 5'd0, 6'd0, 5'd3);
        check("R4 both instances", v1, b0, b1, b2, 3'b001, 6'd12, 6'd0, 6'd0);
        step(1'b0, 5'd0, 6'd0, 1'b0, 1'b1, 5'd19, 6'd12, 5'd3);
        check("R6 CLR_SUPER=0 keeps", v0, a0, a1, a2, 3'b001, 6'd12, 6'd0, 6'd0);
        check("R6 CLR_SUPER=1 clears", v1, b0, b1, b2, 3'b000, 6'd0, 6'd0, 6'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule